// File: doc/BRIEF.md
# Late-Parity Checker with Stretched Error Flag

This block checks a parity bit that reaches it one or two clock edges after the data it covers. On every enabled edge it folds the selected lanes of a 25-lane data bus into a single parity bit. It keeps that bit in a short pipeline until the matching check bit arrives. It then registers the combined result as a partial-parity output. When the combined parity is odd, it drives an active-low error flag.

Once the error flag drops, a small counter holds it low for at least two enabled edges. A fresh error during that window starts the window again. When both chip-select inputs are high, the checker is frozen. An asynchronous reset clears it at once.

Two instances can be chained to cover a wider word. The first instance runs in split mode with the short delay, and its partial-parity output feeds the parity input of the second. The second instance runs in split mode with the long delay and reports the error for the whole word. A stand-alone instance uses the unsplit lane set with the short delay.

Top module: `parity_check_latch`

## Requirements
- R1: With `cfgLate` low, `partialOut` after enabled edge n+1 equals the parity of the selected lanes of `dataIn` sampled at edge n, XOR `parityIn` sampled at edge n+1. Edges n and n+1 are consecutive enabled edges.
- R2: With `cfgLate` high, the check bit is taken two enabled edges after the data. `partialOut` after enabled edge n+2 equals the lane parity from edge n XOR `parityIn` at edge n+2.
- R3: Lanes are numbered from 1, and lane k is `dataIn[k-1]`. The selected lanes depend on the configuration:
  - `cfgSplit` low: lanes 2, 3, 5, 6 and 8 to 25.
  - `cfgSplit` high with `cfgLate` low: lanes 2, 3, 5, 6 and 8 to 14.
  - `cfgSplit` and `cfgLate` both high: lanes 1 to 6, 8, 9, 10, 12 and 13.
- R4: An odd combined parity drives `errN` low. With `cfgSplit` low, this happens one enabled edge after `partialOut` shows the 1. With `cfgSplit` high, it happens on the same edge.
- R5: After `errN` falls, it stays low through the next enabled edge. If no new error arrives, it returns high on the second enabled edge after the fall.
- R6: A new error while `errN` is low restarts the two-edge hold from that edge.
- R7: At an edge where `selN` and `selAltN` are both high, the following are left unchanged: `partialOut`, `errN`, the hold count and the parity pipeline. The `dataIn` and `parityIn` values at that edge are discarded.
- R8: While `rstN` is low, `partialOut` is 0 and `errN` is 1, without any clock edge. The pipeline and the hold count are also cleared.
- R9: In a chain, the second instance's `errN` falls when the combined parity is odd. That parity covers the first instance's lanes from edge n, the second instance's lanes from edge n, and the first instance's `parityIn` from edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 25 | Data lanes; lane k is bit k-1 |
| parityIn | input | 1 | Late check bit, or the upstream partial parity in a chain |
| selN | input | 1 | Chip select, active low |
| selAltN | input | 1 | Second chip select; the block is frozen only when both selects are high |
| cfgLate | input | 1 | 0: check bit one edge late; 1: two edges late |
| cfgSplit | input | 1 | 0: full lane set; 1: half lane set, chosen by `cfgLate` |
| partialOut | output | 1 | Registered partial parity |
| errN | output | 1 | Active-low error flag, held for at least two edges |

## Verification
The assertions assume that `cfgLate` and `cfgSplit` stay fixed while `rstN` is high. Otherwise the pipeline tap would pair a check bit with data from the wrong edge. The bench therefore changes the configuration only while reset is held. The assertions also assume that a frozen edge means both selects are high at that sampled edge. The stimulus drives the selects only at the falling clock edge, and it varies which select is low on the enabled edges.

// File: rtl/parchk_pkg.sv
package parchk_pkg;

  localparam int dataW     = 25;
  localparam int pipeDepth = 2;

  typedef struct packed {
    logic advance;
    logic lateMode;
    logic splitMode;
  } strobe_t;

  // Lane k (1-based) maps to bit k-1.
  function automatic logic [dataW-1:0] laneMask(input int topLane, input logic denseLow);
    logic [dataW-1:0] m;
    m = '0;
    for (int i = 0; i < dataW; i++) begin
      if (denseLow)
        m[i] = ((i + 1) <= 6) || ((i + 1) == 8) || ((i + 1) == 9) ||
               ((i + 1) == 10) || ((i + 1) == 12) || ((i + 1) == 13);
      else
        m[i] = ((i + 1) == 2) || ((i + 1) == 3) || ((i + 1) == 5) || ((i + 1) == 6) ||
               (((i + 1) >= 8) && ((i + 1) <= topLane));
    end
    return m;
  endfunction

  localparam logic [dataW-1:0] maskFull  = laneMask(dataW, 1'b0);
  localparam logic [dataW-1:0] maskFirst = laneMask(14, 1'b0);
  localparam logic [dataW-1:0] maskSecond = laneMask(0, 1'b1);

endpackage

// File: rtl/parchk_datapath.sv
module parchk_datapath
  import parchk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [dataW-1:0] dataIn,
  input  logic             parityIn,
  input  strobe_t          stb,
  output logic             checkBit,
  output logic             partialOut
);

  logic [dataW-1:0]     selMask;
  logic [pipeDepth-1:0] parPipe;
  logic                 freshPar;
  logic                 tapPar;

  always_comb begin
    if (!stb.splitMode)    selMask = maskFull;
    else if (stb.lateMode) selMask = maskSecond;
    else                   selMask = maskFirst;
  end

  assign freshPar = ^(dataIn & selMask);
  assign tapPar   = stb.lateMode ? parPipe[pipeDepth-1] : parPipe[0];
  assign checkBit = tapPar ^ parityIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parPipe    <= '0;
      partialOut <= 1'b0;
    end else if (stb.advance) begin
      parPipe    <= {parPipe[pipeDepth-2:0], freshPar};
      partialOut <= checkBit;
    end
  end

  // R7
  gate_holds_partial_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(partialOut));

  // R7
  gate_holds_pipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(parPipe));

endmodule

// File: rtl/parchk_control.sv
module parchk_control
  import parchk_pkg::*;
#(
  parameter int holdCycles = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    selN,
  input  logic    selAltN,
  input  logic    cfgLate,
  input  logic    cfgSplit,
  input  logic    checkBit,
  input  logic    partialOut,
  output strobe_t stb,
  output logic    errN
);

  localparam int cntW = (holdCycles > 2) ? $clog2(holdCycles) : 1;
  localparam logic [cntW-1:0] holdLoad = cntW'(holdCycles - 1);

  logic [cntW-1:0] holdCnt;
  logic            newErr;

  always_comb begin
    stb.advance   = !(selN && selAltN);
    stb.lateMode  = cfgLate;
    stb.splitMode = cfgSplit;
  end

  // Unsplit: error follows the registered partial parity one edge later.
  assign newErr = cfgSplit ? checkBit : partialOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errN    <= 1'b1;
      holdCnt <= '0;
    end else if (stb.advance) begin
      if (newErr) begin
        errN    <= 1'b0;
        holdCnt <= holdLoad;
      end else if (!errN) begin
        if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
        else               errN    <= 1'b1;
      end
    end
  end

  // R5
  min_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errN) |=> !errN);

  // R4
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errN) |-> $past(stb.advance && newErr));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && newErr) |=> !errN);

  // R7
  gate_holds_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selN && selAltN) |=> $stable(errN));

  // R4
  unsplit_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSplit && stb.advance && partialOut) |=> !errN);

endmodule

// File: rtl/parity_check_latch.sv
module parity_check_latch
  import parchk_pkg::*;
#(
  parameter int holdCycles = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [dataW-1:0] dataIn,
  input  logic             parityIn,
  input  logic             selN,
  input  logic             selAltN,
  input  logic             cfgLate,
  input  logic             cfgSplit,
  output logic             partialOut,
  output logic             errN
);

  strobe_t stb;
  logic    checkBit;

  parchk_control #(.holdCycles(holdCycles)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .selN       (selN),
    .selAltN    (selAltN),
    .cfgLate    (cfgLate),
    .cfgSplit   (cfgSplit),
    .checkBit   (checkBit),
    .partialOut (partialOut),
    .stb        (stb),
    .errN       (errN)
  );

  parchk_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .dataIn     (dataIn),
    .parityIn   (parityIn),
    .stb        (stb),
    .checkBit   (checkBit),
    .partialOut (partialOut)
  );

endmodule

// File: tb/parity_check_latch_bench.sv
`timescale 1ns/1ps
module parity_check_latch_bench;

  typedef struct {
    bit p0;
    bit p1;
    bit ppo;
    bit errN;
    int cnt;
  } mstate_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [24:0] dA = '0, dB = '0;
  logic        parA = 1'b0;
  logic        selN = 1'b1, selAltN = 1'b1;
  logic        lateA = 1'b0, splitA = 1'b0;
  logic        ppoA, errA, ppoB, errB;

  int checks = 0;
  int errors = 0;
  mstate_t mA, mB;
  localparam mstate_t resetState = '{p0: 0, p1: 0, ppo: 0, errN: 1, cnt: 0};

  always #2.5 clk = ~clk;

  parity_check_latch u_parity_check_latch (
    .clk(clk), .rstN(rstN), .dataIn(dA), .parityIn(parA),
    .selN(selN), .selAltN(selAltN), .cfgLate(lateA), .cfgSplit(splitA),
    .partialOut(ppoA), .errN(errA)
  );

  parity_check_latch u_second (
    .clk(clk), .rstN(rstN), .dataIn(dB), .parityIn(ppoA),
    .selN(selN), .selAltN(selAltN), .cfgLate(1'b1), .cfgSplit(1'b1),
    .partialOut(ppoB), .errN(errB)
  );

  // Lane sets from R3 (lane k is bit k-1).
  function automatic logic [24:0] maskOf(bit late, bit split);
    logic [24:0] m = '0;
    if (split && late) begin
      for (int k = 1; k <= 6; k++) m[k-1] = 1'b1;
      m[7] = 1'b1; m[8] = 1'b1; m[9] = 1'b1; m[11] = 1'b1; m[12] = 1'b1;
    end else begin
      m[1] = 1'b1; m[2] = 1'b1; m[4] = 1'b1; m[5] = 1'b1;
      for (int k = 8; k <= (split ? 14 : 25); k++) m[k-1] = 1'b1;
    end
    return m;
  endfunction

  function automatic mstate_t stepModel(mstate_t s, logic [24:0] d, bit par,
                                        bit gate, bit late, bit split);
    mstate_t n = s;
    bit chk, fresh;
    if (gate) return s;
    chk   = (late ? s.p1 : s.p0) ^ par;
    fresh = split ? chk : s.ppo;
    if (fresh) begin
      n.errN = 1'b0; n.cnt = 1;
    end else if (!s.errN) begin
      if (s.cnt > 0) n.cnt = s.cnt - 1;
      else n.errN = 1'b1;
    end
    n.p1  = s.p0;
    n.p0  = ^(d & maskOf(late, split));
    n.ppo = chk;
    return n;
  endfunction

  task automatic check(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic [24:0] da, input logic [24:0] db, input bit pa,
                     input bit gate, input string tp, input string te, input bit chkB);
    mstate_t nA, nB;
    bit s0;
    @(negedge clk);
    dA = da; dB = db; parA = pa;
    s0 = gate | bit'($urandom % 2);
    selN = s0;
    selAltN = gate ? 1'b1 : (s0 ? 1'b0 : bit'($urandom % 2));
    @(posedge clk);
    nA = stepModel(mA, da, pa, gate, lateA, splitA);
    nB = stepModel(mB, db, mA.ppo, gate, 1'b1, 1'b1);
    mA = nA; mB = nB;
    #1;
    check(ppoA, mA.ppo, tp, "partialOut");
    check(errA, mA.errN, te, "errN");
    if (chkB) check(errB, mB.errN, "R9", "chained errN");
  endtask

  task automatic doReset(input bit late, input bit split);
    @(negedge clk);
    rstN = 1'b0;
    mA = resetState; mB = resetState;
    lateA = late; splitA = split;
    dA = '0; parA = 1'b0;
    repeat (2) @(negedge clk);
    #0.5;
    check(ppoA, 1'b0, "R8", "reset partialOut");
    check(errA, 1'b1, "R8", "reset errN");
    check(errB, 1'b1, "R8", "reset chained errN");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runRandom(input int count, input int gatePct, input int errPct,
                           input string tp, input string te, input bit chained);
    for (int i = 0; i < count; i++) begin
      bit good, gate;
      logic [24:0] ra, rb;
      ra = 25'($urandom); rb = 25'($urandom);
      good = chained ? (mA.p0 ^ mB.p0) : (lateA ? mA.p1 : mA.p0);
      gate = ($urandom % 100) < gatePct;
      cyc(ra, rb, good ^ (($urandom % 100) < errPct), gate, tp, te, chained);
    end
  endtask

  task automatic walkLanes(input string tp);
    for (int k = 0; k < 25; k++) begin
      cyc(25'(1) << k, '0, 1'b0, 1'b0, tp, "R4", 1'b0);
      cyc('0, '0, 1'b0, 1'b0, tp, "R4", 1'b0);
      cyc('0, '0, 1'b0, 1'b0, tp, "R4", 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mA = resetState; mB = resetState;

    // Stand-alone, one-edge delay, full lane set
    doReset(1'b0, 1'b0);
    walkLanes("R3");
    runRandom(300, 0, 20, "R1", "R4", 1'b0);

    // R5: single error, then clean check bits
    for (int i = 0; i < 3; i++) cyc('0, '0, mA.p0, 1'b0, "R1", "R5", 1'b0);
    cyc('0, '0, ~mA.p0, 1'b0, "R1", "R5", 1'b0);
    for (int i = 0; i < 5; i++) cyc('0, '0, mA.p0, 1'b0, "R1", "R5", 1'b0);

    // R6: second error while the hold is running
    cyc('0, '0, ~mA.p0, 1'b0, "R1", "R6", 1'b0);
    cyc('0, '0, mA.p0, 1'b0, "R1", "R6", 1'b0);
    cyc('0, '0, mA.p0, 1'b0, "R1", "R6", 1'b0);
    cyc('0, '0, ~mA.p0, 1'b0, "R1", "R6", 1'b0);
    for (int i = 0; i < 5; i++) cyc('0, '0, mA.p0, 1'b0, "R1", "R6", 1'b0);

    // R7: freeze during a hold, then random gating
    cyc('0, '0, ~mA.p0, 1'b0, "R7", "R7", 1'b0);
    cyc('0, '0, mA.p0, 1'b0, "R7", "R7", 1'b0);
    for (int i = 0; i < 4; i++) cyc(25'($urandom), '0, 1'b1, 1'b1, "R7", "R7", 1'b0);
    for (int i = 0; i < 4; i++) cyc('0, '0, mA.p0, 1'b0, "R7", "R7", 1'b0);
    runRandom(300, 30, 20, "R7", "R7", 1'b0);

    // R8: asynchronous reset between edges
    @(negedge clk);
    #0.5 rstN = 1'b0;
    #0.5;
    check(ppoA, 1'b0, "R8", "async partialOut");
    check(errA, 1'b1, "R8", "async errN");

    // Split mode, first-of-pair lane set
    doReset(1'b0, 1'b1);
    walkLanes("R3");
    runRandom(200, 10, 20, "R1", "R4", 1'b0);

    // Split mode, two-edge delay
    doReset(1'b1, 1'b1);
    walkLanes("R3");
    runRandom(300, 10, 20, "R2", "R4", 1'b0);

    // Chain: first instance split/short, second split/long
    doReset(1'b0, 1'b1);
    runRandom(400, 10, 15, "R1", "R4", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule